// File: doc/BRIEF.md
# Triplex Redundant Sensor Voter

The voter takes three redundant signed integer readings, each paired with a self-check bit. It produces a single voted value, a flag that says whether that value can be trusted, and the number of sensors that have not been condemned.

On every clock edge the voter does four things:

- It compares each pair of usable sensors.
- It counts how many consecutive samples each pair has been in disagreement.
- It permanently removes a sensor once both of the pairs that include it have disagreed for too long.
- It computes the output from the sensors that remain usable.

A sensor counts as usable in a sample when its self-check bit is 1 and it has not been condemned. The combination rule depends on how many sensors are usable:

- **Three usable:** a weighted average that gives the outlying value less weight.
- **Two usable:** their plain average.
- **One usable:** that sensor's value is passed through.
- **None usable:** the output holds its last value and is marked invalid.

All outputs are registered. The values seen after a rising clock edge reflect the inputs that were present at that edge, including any sensor condemned at that same edge. The disagreement threshold `THRESH` and the persistence limit `PERSIST` are parameters. The defaults are 10 and 3, with 16-bit data.

Top module: `triplex_voter`

## Requirements
- R1: While reset is low, and after reset until the first sample, `voteValid` is 0, `voteOut` is 0 and `activeCount` is 3.
- R2: A sensor whose self-check bit is 0 takes no part in the vote for that sample. It takes no part in any comparison either, so it can advance no disagreement count and can never be condemned because of that sample.
- R3: A pair of usable sensors disagrees in a sample when the absolute difference of their values is strictly greater than `THRESH`, so a difference of exactly `THRESH` counts as agreement. A pair becomes persistent once it has disagreed in more than `PERSIST` consecutive samples. Any sample in which the pair agrees, or in which the pair is not fully usable, resets its count to zero.
- R4: A sensor is condemned in the sample where both of the pairs that include it are persistent. A condemned sensor is never used again, even when its readings agree with the other sensors once more.
- R5: `activeCount` equals 3 minus the number of condemned sensors. It never increases until reset.
- R6: With three usable sensors, let lo, mid and hi be the sorted values. The outlier is hi when (hi−mid) > (mid−lo); otherwise the outlier is lo. The output is floor((2·outlier + 3·(sum of the other two)) / 8).
- R7: With two usable sensors whose pair is not persistent, the output is floor((a+b)/2).
- R8: With exactly one usable sensor, the output equals that sensor's value.
- R9: With no usable sensor, `voteValid` is 0 and `voteOut` keeps its previous value.
- R10: With exactly two usable sensors whose pair is persistent, `voteValid` is 0 and `voteOut` keeps its previous value. In this case no sensor is condemned.
- R11: Asserting reset again clears all condemned sensors and all disagreement counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sens0Val | input | WIDTH | Reading of sensor 0, two's complement |
| sens0Ok | input | 1 | Self-check bit of sensor 0 (1 = healthy) |
| sens1Val | input | WIDTH | Reading of sensor 1, two's complement |
| sens1Ok | input | 1 | Self-check bit of sensor 1 (1 = healthy) |
| sens2Val | input | WIDTH | Reading of sensor 2, two's complement |
| sens2Ok | input | 1 | Self-check bit of sensor 2 (1 = healthy) |
| voteOut | output | WIDTH | Voted value, two's complement |
| voteValid | output | 1 | 1 when `voteOut` was produced from the current sample |
| activeCount | output | 2 | Number of sensors not condemned (0 to 3) |

## Verification
The assertions check the following on every cycle:

- `activeCount` never rises.
- A condemned sensor stays condemned.
- A pair only becomes persistent after its count has already reached the limit.
- An invalid output does not move.
- A lone usable sensor appears unchanged at the output.
- A three-sensor vote lies between the lowest and highest reading.

Only the bench scenarios can show the exact weighting chosen for the outlier, the rounding of both averages, and the boundary at exactly `THRESH`. They also show the exact sample in which a middle sensor is condemned, that a sensor failing its self-check is never condemned, and that reset restores all three sensors.

// File: rtl/voter_pkg.sv
package voter_pkg;

  localparam int NUM_SENSORS = 3;

  // Strobes from the control unit to the datapath for one sample.
  typedef struct packed {
    logic [NUM_SENSORS-1:0] useMask;   // sensors that take part in the vote
    logic                   pairHold;  // two remaining sensors persistently disagree
  } voteCtl_t;

endpackage

// File: rtl/voter_ctrl.sv
module voter_ctrl
  import voter_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int THRESH  = 10,
  parameter int PERSIST = 3
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_SENSORS-1:0][WIDTH-1:0]  sensVal,
  input  logic [NUM_SENSORS-1:0]             sensOk,
  output voteCtl_t                           ctl,
  output logic [1:0]                         activeCount
);

  localparam int CW = $clog2(PERSIST + 2);
  localparam logic [CW-1:0]  CMAX  = CW'(PERSIST + 1);
  localparam logic [CW-1:0]  PLIM  = CW'(PERSIST);
  localparam logic [WIDTH:0] MAGTH = (WIDTH+1)'(THRESH);

  logic [2:0] faultQ, faultD;
  logic [2:0] usable;
  logic [2:0] persistD;   // pair 0 = sensors 0/1, pair 1 = 0/2, pair 2 = 1/2

  assign usable = sensOk & ~faultQ;

  for (genvar p = 0; p < 3; p++) begin : gPair
    localparam int IA = (p == 2) ? 1 : 0;
    localparam int IB = (p == 0) ? 1 : 2;

    logic signed [WIDTH:0] diff;
    logic [WIDTH:0]        mag;
    logic                  magErr;
    logic [CW-1:0]         cntQ, cntD;

    always_comb begin
      diff   = $signed({sensVal[IA][WIDTH-1], sensVal[IA]})
             - $signed({sensVal[IB][WIDTH-1], sensVal[IB]});
      mag    = diff[WIDTH] ? unsigned'(-diff) : unsigned'(diff);
      magErr = usable[IA] && usable[IB] && (mag > MAGTH);
      if (!magErr)           cntD = '0;
      else if (cntQ == CMAX) cntD = CMAX;
      else                   cntD = cntQ + 1'b1;
      persistD[p] = (cntD > PLIM);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cntQ <= '0;
      else       cntQ <= cntD;
    end

    // R3: persistence only after the count already reached the limit
    assert_persist_lag_R3: assert property (@(posedge clk) disable iff (!rstN)
      persistD[p] |-> (cntQ >= PLIM));
  end

  // A sensor is condemned when both pairs that contain it are persistent.
  assign faultD = faultQ | {persistD[1] & persistD[2],
                            persistD[0] & persistD[2],
                            persistD[0] & persistD[1]};

  always_comb begin
    ctl.useMask  = sensOk & ~faultD;
    ctl.pairHold = ((ctl.useMask == 3'b011) && persistD[0]) ||
                   ((ctl.useMask == 3'b101) && persistD[1]) ||
                   ((ctl.useMask == 3'b110) && persistD[2]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultQ      <= '0;
      activeCount <= 2'd3;
    end else begin
      faultQ      <= faultD;
      activeCount <= 2'(3 - $countones(faultD));
    end
  end

  // R5: sensor count never rises until reset
  assert_count_monotone_R5: assert property (@(posedge clk) disable iff (!rstN)
    activeCount <= $past(activeCount));

  for (genvar k = 0; k < 3; k++) begin : gSticky
    // R4: condemnation is permanent
    assert_fault_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
      faultQ[k] |=> faultQ[k]);
  end

endmodule

// File: rtl/voter_dp.sv
module voter_dp
  import voter_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_SENSORS-1:0][WIDTH-1:0]  sensVal,
  input  voteCtl_t                           ctl,
  output logic [WIDTH-1:0]                   voteOut,
  output logic                               voteValid
);

  localparam int EW = WIDTH + 4;

  logic signed [EW-1:0] ext [3];
  logic signed [EW-1:0] lo, hi, mid, sum3, dHi, dLo, outl, rest, wsum, res3;
  logic signed [EW-1:0] pa, pb, res2, res1, pick;
  logic                 nextValid;
  int                   nUse;

  always_comb begin
    for (int k = 0; k < 3; k++) ext[k] = {{4{sensVal[k][WIDTH-1]}}, sensVal[k]};

    // three-sensor weighted vote
    lo   = (ext[0] < ext[1]) ? ext[0] : ext[1];
    lo   = (lo < ext[2]) ? lo : ext[2];
    hi   = (ext[0] > ext[1]) ? ext[0] : ext[1];
    hi   = (hi > ext[2]) ? hi : ext[2];
    sum3 = ext[0] + ext[1] + ext[2];
    mid  = sum3 - lo - hi;
    dHi  = hi - mid;
    dLo  = mid - lo;
    outl = (dHi > dLo) ? hi : lo;
    rest = sum3 - outl;
    wsum = (outl <<< 1) + (rest <<< 1) + rest;
    res3 = wsum >>> 3;

    // two-sensor average
    case (ctl.useMask)
      3'b011:  begin pa = ext[0]; pb = ext[1]; end
      3'b101:  begin pa = ext[0]; pb = ext[2]; end
      default: begin pa = ext[1]; pb = ext[2]; end
    endcase
    res2 = (pa + pb) >>> 1;

    // single sensor pass-through
    case (ctl.useMask)
      3'b001:  res1 = ext[0];
      3'b010:  res1 = ext[1];
      default: res1 = ext[2];
    endcase

    nUse = $countones(ctl.useMask);
    case (nUse)
      3:       pick = res3;
      2:       pick = res2;
      default: pick = res1;
    endcase
    nextValid = (nUse != 0) && !ctl.pairHold;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      voteOut   <= '0;
      voteValid <= 1'b0;
    end else begin
      voteValid <= nextValid;
      if (nextValid) voteOut <= WIDTH'(pick);
    end
  end

  // R9 / R10: an invalid output does not move
  assert_hold_when_invalid_R9: assert property (@(posedge clk) disable iff (!rstN)
    !voteValid |-> $stable(voteOut));

  // R6: weighted vote stays within the spread of the readings
  assert_weighted_bounds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.useMask == 3'b111) |=>
      (voteValid && ($signed(voteOut) >= $past(lo)) && ($signed(voteOut) <= $past(hi))));

  for (genvar k = 0; k < 3; k++) begin : gSingle
    // R8: a lone usable sensor is passed through unchanged
    assert_single_pass_R8: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.useMask == 3'(1 << k)) |=> (voteValid && (voteOut == $past(sensVal[k]))));
  end

endmodule

// File: rtl/triplex_voter.sv
module triplex_voter
  import voter_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int THRESH  = 10,
  parameter int PERSIST = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] sens0Val,
  input  logic             sens0Ok,
  input  logic [WIDTH-1:0] sens1Val,
  input  logic             sens1Ok,
  input  logic [WIDTH-1:0] sens2Val,
  input  logic             sens2Ok,
  output logic [WIDTH-1:0] voteOut,
  output logic             voteValid,
  output logic [1:0]       activeCount
);

  logic [NUM_SENSORS-1:0][WIDTH-1:0] sensVal;
  logic [NUM_SENSORS-1:0]            sensOk;
  voteCtl_t                          ctl;

  assign sensVal = {sens2Val, sens1Val, sens0Val};
  assign sensOk  = {sens2Ok, sens1Ok, sens0Ok};

  voter_ctrl #(.WIDTH(WIDTH), .THRESH(THRESH), .PERSIST(PERSIST)) u_ctrl (
    .clk(clk), .rstN(rstN), .sensVal(sensVal), .sensOk(sensOk),
    .ctl(ctl), .activeCount(activeCount)
  );

  voter_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .sensVal(sensVal), .ctl(ctl),
    .voteOut(voteOut), .voteValid(voteValid)
  );

endmodule

// File: tb/triplex_voter_tb.sv
`timescale 1ns/1ps
module triplex_voter_tb;

  localparam int W   = 16;
  localparam int TH  = 10;
  localparam int LIM = 3;

  logic clk = 1'b0;
  logic rstN;
  logic [W-1:0] s0, s1, s2;
  logic ok0, ok1, ok2;
  logic [W-1:0] voteOut;
  logic voteValid;
  logic [1:0] activeCount;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench reference state
  int mCnt [3];
  bit [2:0] mFault;
  int mOut, mCount, prevCount;
  bit mValid;
  int PA [3] = '{0, 0, 1};
  int PB [3] = '{1, 2, 2};
  int V  [6] = '{-30, -7, 0, 4, 12, 50};

  triplex_voter #(.WIDTH(W), .THRESH(TH), .PERSIST(LIM)) u_dut (
    .clk(clk), .rstN(rstN),
    .sens0Val(s0), .sens0Ok(ok0), .sens1Val(s1), .sens1Ok(ok1),
    .sens2Val(s2), .sens2Ok(ok2),
    .voteOut(voteOut), .voteValid(voteValid), .activeCount(activeCount)
  );

  always #10 clk = ~clk;

  function automatic int absI(int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic int wavg(int a, int b, int c);
    int lo, hi, mid, o;
    lo = (a < b) ? a : b; lo = (lo < c) ? lo : c;
    hi = (a > b) ? a : b; hi = (hi > c) ? hi : c;
    mid = a + b + c - lo - hi;
    o = ((hi - mid) > (mid - lo)) ? hi : lo;
    return (2 * o + 3 * (a + b + c - o)) >>> 3;
  endfunction

  task automatic modelReset();
    for (int p = 0; p < 3; p++) mCnt[p] = 0;
    mFault = 3'b000; mOut = 0; mValid = 0; mCount = 3; prevCount = 3;
  endtask

  task automatic check(input string tag);
    int got;
    got = $signed(voteOut);
    checks++;
    if (got != mOut || voteValid != mValid || int'(activeCount) != mCount) begin
      failures++;
      $display("FAIL %s: out=%0d valid=%0d count=%0d expected out=%0d valid=%0d count=%0d",
               tag, got, voteValid, activeCount, mOut, mValid, mCount);
    end
    checks++;
    if (int'(activeCount) > prevCount) begin
      failures++;
      $display("FAIL R5: count rose to %0d, expected at most %0d", activeCount, prevCount);
    end
    prevCount = int'(activeCount);
  endtask

  // apply one sample at a falling edge, advance through one rising edge, check
  task automatic step(input int v0, input int v1, input int v2,
                      input bit c0, input bit c1, input bit c2, input string tag);
    int v [3];
    bit [2:0] u, c;
    bit pers [3];
    int n;
    bit hold;
    s0 = W'(v0); s1 = W'(v1); s2 = W'(v2);
    ok0 = c0; ok1 = c1; ok2 = c2;
    v[0] = v0; v[1] = v1; v[2] = v2;
    c = {c2, c1, c0};
    u = c & ~mFault;
    for (int p = 0; p < 3; p++) begin
      if (u[PA[p]] && u[PB[p]] && absI(v[PA[p]] - v[PB[p]]) > TH)
        mCnt[p] = (mCnt[p] >= LIM + 1) ? LIM + 1 : mCnt[p] + 1;
      else
        mCnt[p] = 0;
      pers[p] = mCnt[p] > LIM;
    end
    mFault[0] = mFault[0] | (pers[0] & pers[1]);
    mFault[1] = mFault[1] | (pers[0] & pers[2]);
    mFault[2] = mFault[2] | (pers[1] & pers[2]);
    u = c & ~mFault;
    n = int'(u[0]) + int'(u[1]) + int'(u[2]);
    hold = (n == 0) || (n == 2 && ((u == 3'b011 && pers[0]) ||
                                   (u == 3'b101 && pers[1]) ||
                                   (u == 3'b110 && pers[2])));
    if (hold) mValid = 0;
    else begin
      mValid = 1;
      if (n == 3) mOut = wavg(v0, v1, v2);
      else if (n == 2) begin
        if (u == 3'b011) mOut = (v0 + v1) >>> 1;
        else if (u == 3'b101) mOut = (v0 + v2) >>> 1;
        else mOut = (v1 + v2) >>> 1;
      end else mOut = u[0] ? v0 : (u[1] ? v1 : v2);
    end
    mCount = 3 - (int'(mFault[0]) + int'(mFault[1]) + int'(mFault[2]));
    @(negedge clk);
    check(tag);
  endtask

  task automatic doReset(input string tag);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    modelReset();
    check(tag);
    rstN = 1'b1;
  endtask

  initial begin
    rstN = 1'b0; s0 = '0; s1 = '0; s2 = '0; ok0 = 1; ok1 = 1; ok2 = 1;
    modelReset();
    @(negedge clk);
    doReset("R1 reset state");

    // R6: three-sensor weighted vote over a value grid, with calm steps between
    foreach (V[a]) foreach (V[b]) foreach (V[c]) begin
      step(V[a], V[b], V[c], 1, 1, 1, "R6 weighted vote");
      step(0, 0, 0, 1, 1, 1, "R6 calm");
    end

    // R3: a difference of exactly THRESH never counts as disagreement
    for (int i = 0; i < 8; i++) step(0, TH, 0, 1, 1, 1, "R3 equal-threshold agree");
    // R3: LIM disagreeing samples, then agreement, repeated; no condemnation
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < LIM; i++) step(0, TH + 1, 0, 1, 1, 1, "R3 short disagreement");
      step(3, 3, 3, 1, 1, 1, "R3 count cleared");
    end

    // R2: sensor 1 fails self-check while wild; it must never be condemned
    for (int i = 0; i < 8; i++) step(5, 900, 7, 1, 0, 1, "R2 self-check excluded");
    step(5, 6, 7, 1, 1, 1, "R2 sensor back in vote");

    // R4: middle sensor off for LIM+1 samples is condemned at the last one
    for (int i = 0; i <= LIM; i++) step(0, 100, 0, 1, 1, 1, "R4 middle isolation");
    step(4, 100, 8, 1, 1, 1, "R4 condemned sensor ignored");
    step(4, 6, 8, 1, 1, 1, "R4 stays out after agreeing");

    // R7: two-sensor averages over the grid
    foreach (V[a]) foreach (V[c]) begin
      step(V[a], 1, V[c], 1, 1, 1, "R7 two-sensor average");
      step(0, 0, 0, 1, 1, 1, "R7 calm");
    end
    step(-7, 0, 0, 1, 1, 1, "R7 negative odd sum");

    // R10: the two survivors persistently disagree
    step(11, 0, 11, 1, 1, 1, "R10 valid before hold");
    for (int i = 0; i < LIM + 3; i++) step(0, 0, 40, 1, 1, 1, "R10 persistent pair hold");

    // R8: one usable sensor by self-check
    foreach (V[c]) step(123, 0, V[c], 0, 1, 1, "R8 single pass-through");

    // R9: nothing usable
    for (int i = 0; i < 3; i++) step(77, 88, 99, 0, 0, 0, "R9 none usable hold");

    // R11: reset restores three sensors
    doReset("R11 reset clears faults");
    step(10, 20, 30, 1, 1, 1, "R11 all three voting");

    // R5: all three diverge and are condemned together
    for (int i = 0; i <= LIM; i++) step(0, 50, 100, 1, 1, 1, "R5 total divergence");
    for (int i = 0; i < 3; i++) step(5, 5, 5, 1, 1, 1, "R5 count stays zero");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule